// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus side of a 4096-byte serial memory that sits on a two-wire bus. It oversamples the clock and data lines with a fast system clock and finds the start and stop conditions. It then shifts in a slave address byte, a two-byte memory address and data bytes, and answers each byte by pulling the data line low through an open-drain enable. Incoming write bytes go to a separate page-write controller. Outgoing bytes come from a synchronous array read port.

An internal address counter always points one past the last byte that was read or written. A master can load that counter with a dummy write and then stop (set-address), or follow the dummy write with a repeated start to do a random read. Reads continue byte after byte for as long as the master acknowledges. While the page-write controller reports a write cycle in progress, the engine refuses its slave address, so masters can poll for completion.

Top module: `twi_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. No transfer is answered until a start has been seen.
- R2: The slave address byte is received MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal `sel_pins[2:0]`. Bit 0 set to 1 selects a read and 0 selects a write. A matching byte is acknowledged on the ninth clock.
- R3: On a mismatched slave address no acknowledge is driven. All further bytes are ignored (never acknowledged) until the next start.
- R4: In a write, the first address byte supplies address bits 11..8 in its low nibble, and its upper nibble is ignored. The second address byte supplies bits 7..0. Both bytes are acknowledged, and the counter is loaded when the second one is accepted.
- R5: In a read, 8 bits are sent MSB first and SDA is released for the ninth clock. If the master drives low there, the next byte follows. If the master leaves it high, SDA stays released until the next start or stop.
- R6: A read without a preceding address returns the byte at the counter. Each byte read advances the counter by one.
- R7: Read increments wrap from address 0xFFF to 0x000.
- R8: A dummy write of both address bytes followed by a stop only loads the counter. Followed by a repeated start and a read address, it returns the byte at the loaded address.
- R9: Each write data byte is acknowledged and presented once on `wr_valid`/`wr_addr`/`wr_data`. The address then advances within its 32-byte page: offset 31 goes back to offset 0 of the same page.
- R10: `wr_commit` pulses once after a stop that ends a write with at least one data byte. It does not pulse after a stop with no data, or when a repeated start ends the write.
- R11: While `wr_busy` is high the slave address is not acknowledged, and SDA stays released.
- R12: A repeated start in the middle of a byte abandons that byte and re-enters the slave address phase. The counter keeps its value unless the second address byte had already been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sel_pins | input | 3 | Strapped select bits compared with slave address bits 3..1 |
| wr_busy | input | 1 | Nonvolatile write cycle in progress |
| rd_data | input | 8 | Array read data, valid the cycle after `rd_en` and held until the next one |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| rd_en | output | 1 | Array read request |
| rd_addr | output | 12 | Array read address |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 12 | Address of the received write byte |
| wr_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-cycle pulse that starts the nonvolatile write |

## Verification
The hardest case to reach is a repeated start that lands partway through a byte after only the first address byte was accepted. That state is brief, and it must leave the counter untouched. The bench drives the bus lines bit by bit. It sends four bits of a byte, raises the data line during the low clock phase, and then forms the start, so the engine sees a start with its bit count at four. A random-read style check that follows shows whether the earlier counter value survived. The wrap at the top of the array is reached by first loading the address 0xFFE and then running a four-byte sequential read.

// File: rtl/twi_mem_pkg.sv
// Shared definitions for the two-wire memory slave engine.
// Assumes an 8-bit slave address byte: 4-bit type code, select bits, R/W.
package twi_mem_pkg;
    // Which byte of a transfer is being shifted.
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a start; bus activity ignored
        PH_DEV,    // slave address byte
        PH_AHI,    // high address byte
        PH_ALO,    // low address byte
        PH_WDAT,   // write data bytes
        PH_RDAT    // read data bytes
    } phase_t;

    localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronises the raw clock and data lines into the system clock domain
// and reports clock edges and start/stop conditions.
// Assumes STAGES >= 2 and a system clock well above the bus clock rate.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;
    logic              scl_lvl;

    // Shift both lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twi_addr_ctr.sv
// Internal address counter: holds last accessed byte address plus one.
// Reads wrap over the whole array; writes wrap inside one page.
// Assumes load, inc_rd and inc_wr are never requested together.
module twi_addr_ctr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [ADDR_W-1:0] cnt,
    output logic              upd
);
    localparam logic [ADDR_W-1:0] ONE = 1;
    logic [ADDR_W-1:0] wr_next;

    // Select the write increment shape from the page size.
    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign wr_next = cnt + ONE;
        end else begin : g_paged
            localparam logic [PAGE_W-1:0] PG_ONE = 1;
            assign wr_next = {cnt[ADDR_W-1:PAGE_W], cnt[PAGE_W-1:0] + PG_ONE};

            // R9
            page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_wr && !load) |=> cnt[ADDR_W-1:PAGE_W] == $past(cnt[ADDR_W-1:PAGE_W]));
        end
    endgenerate

    // Update the counter and flag the update for the read prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            upd <= 1'b0;
        end else begin
            if (load)        cnt <= load_val;
            else if (inc_rd) cnt <= cnt + ONE;
            else if (inc_wr) cnt <= wr_next;
            upd <= load | inc_rd | inc_wr;
        end
    end

    // R7
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rd && !load && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/twi_mem_slave.sv
// Bus-facing protocol engine of a serial memory. Decodes slave address,
// address bytes and data bytes, drives acknowledges and read data through
// an open-drain enable, and talks to a write controller and a read port.
// Assumes rd_data is valid one clock after rd_en and held until the next.
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        sel_pins,
    input  logic              wr_busy,
    input  logic [7:0]        rd_data,
    output logic              sda_drive_low,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int HI_W = ADDR_W - 8;

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    phase_t            phase;
    logic [3:0]        bitcnt;
    logic [7:0]        rx_sh, tx_sh;
    logic              rw_q, wrote_q, fetch_q, mnack_q, sda_low_q;
    logic [HI_W-1:0]   hi_q;
    logic              byte_end, dev_match;
    logic              ctr_load, ctr_inc_rd, ctr_inc_wr, ctr_upd;
    logic [ADDR_W-1:0] ctr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Byte boundary and counter control decode.
    always_comb begin
        byte_end   = scl_fall && (bitcnt == 4'd8);
        dev_match  = (rx_sh[7:4] == TYPE_CODE) && (rx_sh[3:1] == sel_pins) && !wr_busy;
        ctr_load   = byte_end && (phase == PH_ALO);
        ctr_inc_wr = byte_end && (phase == PH_WDAT);
        ctr_inc_rd = byte_end && (phase == PH_RDAT);
    end

    twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({hi_q, rx_sh}),
        .inc_rd(ctr_inc_rd), .inc_wr(ctr_inc_wr), .cnt(ctr), .upd(ctr_upd)
    );

    // Prefetch the byte at the counter after every update or read select.
    assign rd_en         = ctr_upd | fetch_q;
    assign rd_addr       = ctr;
    assign sda_drive_low = sda_low_q;

    // Protocol sequencer: bit counting, acknowledges, data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_q      <= 1'b0;
            wrote_q   <= 1'b0;
            fetch_q   <= 1'b0;
            mnack_q   <= 1'b0;
            sda_low_q <= 1'b0;
            hi_q      <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            fetch_q   <= 1'b0;
            if (stop_det) begin
                phase     <= PH_IDLE;
                bitcnt    <= '0;
                sda_low_q <= 1'b0;
                wr_commit <= wrote_q;
                wrote_q   <= 1'b0;
            end else if (start_det) begin
                phase     <= PH_DEV;
                bitcnt    <= '0;
                sda_low_q <= 1'b0;
                wrote_q   <= 1'b0;
            end else begin
                if (scl_rise && phase != PH_IDLE && bitcnt != 4'd9) begin
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt < 4'd8) rx_sh <= {rx_sh[6:0], sda_lvl};
                    if (bitcnt == 4'd8) mnack_q <= sda_lvl;
                end
                if (scl_fall && phase != PH_IDLE) begin
                    if (bitcnt == 4'd8) begin
                        case (phase)
                            PH_DEV: begin
                                if (dev_match) begin
                                    sda_low_q <= 1'b1;
                                    rw_q      <= rx_sh[0];
                                    fetch_q   <= rx_sh[0];
                                end else begin
                                    phase  <= PH_IDLE;
                                    bitcnt <= '0;
                                end
                            end
                            PH_AHI: begin
                                sda_low_q <= 1'b1;
                                hi_q      <= rx_sh[HI_W-1:0];
                            end
                            PH_ALO:  sda_low_q <= 1'b1;
                            PH_WDAT: begin
                                sda_low_q <= 1'b1;
                                wr_valid  <= 1'b1;
                                wr_addr   <= ctr;
                                wr_data   <= rx_sh;
                                wrote_q   <= 1'b1;
                            end
                            default: sda_low_q <= 1'b0;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt    <= '0;
                        sda_low_q <= 1'b0;
                        case (phase)
                            PH_DEV: begin
                                if (rw_q) begin
                                    phase     <= PH_RDAT;
                                    tx_sh     <= rd_data;
                                    sda_low_q <= ~rd_data[7];
                                end else begin
                                    phase <= PH_AHI;
                                end
                            end
                            PH_AHI: phase <= PH_ALO;
                            PH_ALO: phase <= PH_WDAT;
                            PH_RDAT: begin
                                if (mnack_q) begin
                                    phase <= PH_IDLE;
                                end else begin
                                    tx_sh     <= rd_data;
                                    sda_low_q <= ~rd_data[7];
                                end
                            end
                            default: phase <= phase;
                        endcase
                    end else if (bitcnt != 4'd0 && phase == PH_RDAT) begin
                        tx_sh     <= {tx_sh[6:0], 1'b0};
                        sda_low_q <= ~tx_sh[6];
                    end
                end
            end
        end
    end

    // R11
    busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEV && bitcnt != 4'd9 && wr_busy) |=> !sda_drive_low);

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RDAT && scl_fall && bitcnt == 4'd9 && mnack_q) |=> (phase == PH_IDLE && !sda_drive_low));

    // R10
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_det));

    // R9
    wr_port_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (sda_drive_low && phase == PH_WDAT));
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] sel_pins = 3'b101;
    logic wr_busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic sda_drive_low, rd_en, wr_valid, wr_commit;
    logic [11:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    wire sda_line = sda_m & ~sda_drive_low;

    int n_chk = 0, n_fail = 0, n_wr = 0, n_commit = 0;
    logic [11:0] cap_addr [16];
    logic [7:0]  cap_data [16];
    bit done = 0;

    always #4 clk = ~clk;

    twi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sel_pins(sel_pins), .wr_busy(wr_busy), .rd_data(rd_data),
        .sda_drive_low(sda_drive_low), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] pat(input logic [11:0] a);
        return (a[7:0] * 8'd3) ^ {4'h0, a[11:8]};
    endfunction

    // Array model and write-port capture
    always @(posedge clk) begin
        if (rd_en) rd_data <= pat(rd_addr);
        if (wr_valid && n_wr < 16) begin
            cap_addr[n_wr] <= wr_addr;
            cap_data[n_wr] <= wr_data;
        end
        if (wr_valid) n_wr <= n_wr + 1;
        if (wr_commit) n_commit <= n_commit + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; tick(10); sda_m = 0; tick(10); scl_m = 0; tick(5);
    endtask
    task automatic bus_rstart();
        sda_m = 1; tick(5); scl_m = 1; tick(10); sda_m = 0; tick(10); scl_m = 0; tick(5);
    endtask
    task automatic bus_stop();
        sda_m = 0; tick(5); scl_m = 1; tick(10); sda_m = 1; tick(10);
    endtask
    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(5); scl_m = 1; tick(10); scl_m = 0; tick(5);
        end
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1; tick(5); scl_m = 1; tick(5); ack = sda_drive_low; tick(5); scl_m = 0; tick(5);
    endtask
    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(5); scl_m = 1; tick(5); b[i] = sda_line; tick(5); scl_m = 0; tick(5);
        end
        sda_m = ~mack; tick(5); scl_m = 1; tick(10); scl_m = 0; tick(5); sda_m = 1;
    endtask
    task automatic set_addr(input logic [11:0] a);
        logic k;
        bus_start(); send_byte(8'hAA, k); send_byte({4'h0, a[11:8]}, k); send_byte(a[7:0], k); bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int c0, lowseen;
        tick(6);
        chk("R1 reset sda", sda_drive_low, 0);
        chk("R1 reset wr_valid", wr_valid, 0);
        rst_n = 1; tick(4);
        // R1: a byte clocked without a start is never answered
        send_byte(8'hAA, ack);
        chk("R1 no start no ack", ack, 0);
        bus_stop();

        // R2, R3: type code sweep (write bit), extra byte ignored on mismatch
        for (int t = 0; t < 16; t++) begin
            bus_start(); send_byte({t[3:0], 3'b101, 1'b0}, ack);
            chk("R2 type code ack", ack, (t == 10) ? 1 : 0);
            if (t != 10) begin
                send_byte(8'h00, ack);
                chk("R3 ignored after mismatch", ack, 0);
            end
            bus_stop();
        end
        // R2: select bit sweep
        for (int s = 0; s < 8; s++) begin
            bus_start(); send_byte({4'b1010, s[2:0], 1'b0}, ack);
            chk("R2 select ack", ack, (s == 5) ? 1 : 0);
            bus_stop();
        end

        // R4, R8: set-address with nonzero ignored upper nibble
        c0 = n_commit;
        bus_start(); send_byte(8'hAA, ack); chk("R4 dev ack", ack, 1);
        send_byte(8'hF1, ack); chk("R4 hi byte ack", ack, 1);
        send_byte(8'h23, ack); chk("R4 lo byte ack", ack, 1);
        bus_stop(); tick(4);
        chk("R10 no commit without data", n_commit, c0);
        // R6: current-address reads
        bus_start(); send_byte(8'hAB, ack); recv_byte(0, d); bus_stop();
        chk("R8 set-address then current read", d, pat(12'h123));
        bus_start(); send_byte(8'hAB, ack); recv_byte(0, d); bus_stop();
        chk("R6 counter advanced", d, pat(12'h124));

        // R7: sequential read across the top of the array
        set_addr(12'hFFE);
        bus_start(); send_byte(8'hAB, ack);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, d);
            chk("R7 sequential wrap", d, pat(12'(12'hFFE + i)));
        end
        // R5: after master nack the line stays released
        lowseen = 0;
        for (int i = 0; i < 9; i++) begin
            tick(5); scl_m = 1; tick(5); if (sda_drive_low) lowseen++; tick(5); scl_m = 0; tick(5);
        end
        chk("R5 released after nack", lowseen, 0);
        bus_stop();

        // R8: random read via repeated start
        bus_start(); send_byte(8'hAA, ack); send_byte(8'h04, ack); send_byte(8'h56, ack);
        bus_rstart(); send_byte(8'hAB, ack); chk("R8 read select ack", ack, 1);
        recv_byte(0, d); bus_stop();
        chk("R8 random read", d, pat(12'h456));

        // R9, R10: page write wrapping inside the page
        c0 = n_commit;
        bus_start(); send_byte(8'hAA, ack); send_byte(8'h01, ack); send_byte(8'h3C, ack);
        for (int i = 0; i < 6; i++) begin
            send_byte(8'hC0 + 8'(i), ack);
            chk("R9 data ack", ack, 1);
        end
        bus_stop(); tick(4);
        chk("R9 byte count", n_wr, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R9 page addr", cap_addr[i], 12'h120 + ((12'h1C + i) % 32));
            chk("R9 data", cap_data[i], 8'hC0 + i);
        end
        chk("R10 commit after stop", n_commit, c0 + 1);
        bus_start(); send_byte(8'hAB, ack); recv_byte(0, d); bus_stop();
        chk("R9 counter stays in page", d, pat(12'h122));

        // R11: busy refuses address and keeps line released
        wr_busy = 1; c0 = n_commit;
        bus_start(); send_byte(8'hAA, ack); chk("R11 busy write no ack", ack, 0);
        bus_rstart(); send_byte(8'hAB, ack); chk("R11 busy read no ack", ack, 0);
        bus_stop();
        wr_busy = 0;
        bus_start(); send_byte(8'hAA, ack); chk("R11 ack after busy", ack, 1);
        bus_stop(); tick(4);
        chk("R10 no commit address only", n_commit, c0);

        // R12: repeated start mid-byte after only the high address byte
        bus_start(); send_byte(8'hAA, ack); send_byte(8'h07, ack);
        send_bits(8'h89, 4); bus_rstart();
        send_byte(8'hAB, ack); chk("R12 address phase re-entered", ack, 1);
        recv_byte(0, d); bus_stop();
        chk("R12 counter untouched", d, pat(12'h123));

        // R10: repeated start ends a write without commit
        c0 = n_commit;
        bus_start(); send_byte(8'hAA, ack); send_byte(8'h00, ack); send_byte(8'h10, ack);
        send_byte(8'h55, ack);
        bus_rstart(); send_byte(8'hAB, ack); recv_byte(0, d); bus_stop(); tick(4);
        chk("R9 write addr", cap_addr[6], 12'h010);
        chk("R10 no commit on repeated start", n_commit, c0);
        chk("R6 read after write", d, pat(12'h011));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule